// File: doc/BRIEF.md
# Gated Clock Selector Fanout

This block chooses one of two incoming clocks and copies the chosen clock onto a bank of true/complement output pairs. A single clock-enable request gates every pair at once. The request is sampled on the rising edge of the chosen clock, and a two-state gate machine then acts on it at the next falling edge. An output therefore starts or stops only while the clock is low, and no high pulse is ever cut short.

A gated pair rests with its true line low and its complement line high. A separate output-enable input takes precedence over everything else and floats every output line, whatever the select and gate state. An active-low asynchronous reset closes the gate, so after reset the outputs rest until an asserted request has been seen on a rising edge and acted on at the following falling edge.

The gate machine has two states. GATE_OFF means the pairs are held at rest. GATE_ON means the pairs follow the chosen clock. The transition OPEN (GATE_OFF to GATE_ON) happens on a falling edge when the request sampled at the preceding rising edge was high. The transition CLOSE (GATE_ON to GATE_OFF) happens on a falling edge when that sample was low. HOLD_OFF and HOLD_ON keep the current state. Reset forces GATE_OFF.

Top module: `clkfan_top`

## Requirements
- R1: With `per_sel` low, the true outputs of an open gate follow `std_clk`.
- R2: With `per_sel` high, the true outputs of an open gate follow `per_clk` and not `std_clk`.
- R3: With the gate closed and `out_en` high, every `fan_t` bit is 0 and every `fan_c` bit is 1.
- R4: With the gate open and `out_en` high, `fan_t` is all ones during the chosen clock's high phase and all zeros during its low phase, and `fan_c` is always the bitwise inverse of `fan_t`.
- R5: With `out_en` low, all `fan_t` and `fan_c` lines are high impedance in both clock phases and whether the gate is open or closed. They return to driven levels as soon as `out_en` rises.
- R6: A change of `clk_en` takes effect only after a rising edge and then a falling edge of the chosen clock. The high phase that follows the first such rising edge still shows the old state, and the outputs are never high while the chosen clock is low.
- R7: While `rst_n` is low, and after its release until an asserted `clk_en` has passed through R6's rising-then-falling sequence, the outputs rest as in R3.
- R8: All pairs carry the same value at all times, because they share one gate and one output enable.
- R9: No high pulse on a true output is shorter than the high phase of the chosen input clock, however `clk_en` is toggled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| std_clk | input | 1 | Standard clock source, routed when `per_sel` is low |
| per_clk | input | 1 | Peripheral clock source, routed when `per_sel` is high |
| per_sel | input | 1 | Source select: 0 routes `std_clk`, 1 routes `per_clk` |
| clk_en | input | 1 | Gate request, acted on per R6 |
| out_en | input | 1 | 1 drives the outputs, 0 floats all of them |
| rst_n | input | 1 | Active-low asynchronous reset; closes the gate |
| fan_t | output | N_PAIRS | True outputs, one bit per pair |
| fan_c | output | N_PAIRS | Complement outputs, one bit per pair |

## Verification
The assertions assume that `per_sel` changes only while the gate is closed. Source switching is unsynchronized, so a select change on an open gate could produce a clock edge that no requirement describes. The bench keeps to this assumption: it closes the gate and waits for CLOSE before it moves `per_sel`, and only then reopens the gate. The assertions also read the outputs only while `out_en` is high. The floating state is therefore checked by the bench, through pull-ups on its own nets. A floating true/complement pair reads all ones on both lines, a value that driven complementary lines can never show.

// File: rtl/clkfan_pkg.sv
package clkfan_pkg;

    // Gate machine states.
    typedef enum logic {
        GATE_OFF = 1'b0,
        GATE_ON  = 1'b1
    } gate_state_e;

    // Resting levels of a closed pair.
    localparam logic REST_TRUE = 1'b0;
    localparam logic REST_COMP = 1'b1;

endpackage

// File: rtl/clkfan_src_mux.sv
module clkfan_src_mux (
    input  logic std_clk,
    input  logic per_clk,
    input  logic per_sel,
    output logic sel_clk
);
    // Plain combinational source choice; switching is not glitch-protected.
    always_comb begin
        if (per_sel) sel_clk = per_clk;
        else         sel_clk = std_clk;
    end
endmodule

// File: rtl/clkfan_gate_fsm.sv
module clkfan_gate_fsm
    import clkfan_pkg::*;
(
    input  logic sel_clk,
    input  logic rst_n,
    input  logic clk_en,
    output logic gate_open
);
    logic        en_seen;
    gate_state_e state_q;
    gate_state_e state_d;

    // Request sampled on the rising edge, so a change always needs rise then fall.
    always_ff @(posedge sel_clk or negedge rst_n) begin
        if (!rst_n) en_seen <= 1'b0;
        else        en_seen <= clk_en;
    end

    // State register: moves only on the falling edge, while the clock is low.
    always_ff @(negedge sel_clk or negedge rst_n) begin
        if (!rst_n) state_q <= GATE_OFF;
        else        state_q <= state_d;
    end

    // Transitions: OPEN, CLOSE, HOLD_OFF, HOLD_ON.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GATE_OFF: state_d = en_seen ? GATE_ON  : GATE_OFF;
            GATE_ON:  state_d = en_seen ? GATE_ON  : GATE_OFF;
            default:  state_d = GATE_OFF;
        endcase
    end

    // Output process.
    always_comb begin
        unique case (state_q)
            GATE_ON:  gate_open = 1'b1;
            default:  gate_open = 1'b0;
        endcase
    end
endmodule

// File: rtl/clkfan_pair.sv
module clkfan_pair
    import clkfan_pkg::*;
(
    input  logic sel_clk,
    input  logic gate_open,
    input  logic out_en,
    output logic line_t,
    output logic line_c
);
    logic val_t;

    // AND gating holds the line low through every closed cycle.
    always_comb begin
        if (gate_open) val_t = sel_clk;
        else           val_t = REST_TRUE;
    end

    assign line_t = out_en ? val_t  : 1'bz;
    assign line_c = out_en ? ~val_t : 1'bz;
endmodule

// File: rtl/clkfan_top.sv
module clkfan_top #(
    parameter int N_PAIRS = 4
) (
    input  logic               std_clk,
    input  logic               per_clk,
    input  logic               per_sel,
    input  logic               clk_en,
    input  logic               out_en,
    input  logic               rst_n,
    output logic [N_PAIRS-1:0] fan_t,
    output logic [N_PAIRS-1:0] fan_c
);
    logic sel_clk;
    logic gate_open;

    clkfan_src_mux u_mux (
        .std_clk (std_clk),
        .per_clk (per_clk),
        .per_sel (per_sel),
        .sel_clk (sel_clk)
    );

    clkfan_gate_fsm u_fsm (
        .sel_clk   (sel_clk),
        .rst_n     (rst_n),
        .clk_en    (clk_en),
        .gate_open (gate_open)
    );

    for (genvar i = 0; i < N_PAIRS; i++) begin : g_pair
        clkfan_pair u_pair (
            .sel_clk   (sel_clk),
            .gate_open (gate_open),
            .out_en    (out_en),
            .line_t    (fan_t[i]),
            .line_c    (fan_c[i])
        );
    end
endmodule

// File: rtl/clkfan_chk.sv
module clkfan_chk #(
    parameter int N_PAIRS = 4
) (
    input logic               mclk,
    input logic               rst_n,
    input logic               out_en,
    input logic               gate_open,
    input logic [N_PAIRS-1:0] fan_t,
    input logic [N_PAIRS-1:0] fan_c
);
    localparam logic [N_PAIRS-1:0] ALL1 = '1;
    localparam logic [N_PAIRS-1:0] ALL0 = '0;

    AST_REST_LEVELS: assert property (@(negedge mclk) disable iff (!rst_n)
        (out_en && !gate_open) |-> (fan_t == ALL0 && fan_c == ALL1)); // R3

    AST_OPEN_HIGH: assert property (@(negedge mclk) disable iff (!rst_n)
        (out_en && gate_open) |-> (fan_t == ALL1)); // R4

    AST_COMPLEMENT: assert property (@(negedge mclk) disable iff (!rst_n)
        out_en |-> (fan_c == ~fan_t)); // R4

    AST_LOW_BEFORE_RISE: assert property (@(posedge mclk) disable iff (!rst_n)
        out_en |-> (fan_t == ALL0)); // R6

    AST_PAIRS_EQUAL: assert property (@(negedge mclk) disable iff (!rst_n)
        out_en |-> (fan_t == ALL0 || fan_t == ALL1)); // R8
endmodule

bind clkfan_top clkfan_chk #(.N_PAIRS(N_PAIRS)) u_chk (
    .mclk      (sel_clk),
    .rst_n     (rst_n),
    .out_en    (out_en),
    .gate_open (gate_open),
    .fan_t     (fan_t),
    .fan_c     (fan_c)
);

// File: tb/clkfan_top_test.sv
`timescale 1ns/1ps
module clkfan_top_test;
    localparam int NP = 4;
    localparam logic [NP-1:0] F = '1;
    localparam logic [NP-1:0] Z0 = '0;

    logic std_clk = 1'b0;
    logic per_clk = 1'b0;
    logic per_sel, clk_en, out_en, rst_n;
    tri1 [NP-1:0] fan_t_w;
    tri1 [NP-1:0] fan_c_w;

    int checks = 0;
    int fails  = 0;

    bit  mon_on = 1'b0;
    real rise_t = 0.0;
    real min_hi = 1.0e9;
    int  pulses = 0;

    clkfan_top #(.N_PAIRS(NP)) uut (
        .std_clk (std_clk),
        .per_clk (per_clk),
        .per_sel (per_sel),
        .clk_en  (clk_en),
        .out_en  (out_en),
        .rst_n   (rst_n),
        .fan_t   (fan_t_w),
        .fan_c   (fan_c_w)
    );

    always #4  std_clk = ~std_clk;   // 125 MHz
    always #10 per_clk = ~per_clk;   // 50 MHz

    // High-pulse width monitor on pair 0 (R9).
    always @(fan_t_w[0]) begin
        if (mon_on && out_en) begin
            if (fan_t_w[0]) rise_t = $realtime;
            else if (rise_t > 0.0) begin
                pulses++;
                if ($realtime - rise_t < min_hi) min_hi = $realtime - rise_t;
            end
        end
    end

    task automatic chk(input bit ok, input string req,
                       input logic [2*NP-1:0] act, input logic [2*NP-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic expect_out(input string req, input logic [NP-1:0] et,
                              input logic [NP-1:0] ec);
        chk((fan_t_w == et) && (fan_c_w == ec), req, {fan_t_w, fan_c_w}, {et, ec});
    endtask

    task automatic hi_s; @(posedge std_clk); #2; endtask
    task automatic lo_s; @(negedge std_clk); #2; endtask

    task automatic t_reset;
        per_sel = 1'b0; clk_en = 1'b1; out_en = 1'b1; rst_n = 1'b0;
        hi_s(); expect_out("R7 rest in reset high phase", Z0, F);
        lo_s(); expect_out("R3 rest in reset low phase", Z0, F);
        @(negedge std_clk); #1; rst_n = 1'b1;
        hi_s(); expect_out("R7 not open before falling edge", Z0, F);
        lo_s(); expect_out("R6 low phase after open", Z0, F);
        hi_s(); expect_out("R1 open follows std high", F, Z0);
        lo_s(); expect_out("R4 open low phase", Z0, F);
    endtask

    task automatic t_latency;
        hi_s(); clk_en = 1'b0;                     // drop during high
        hi_s(); expect_out("R6 drop in high: next high still open", F, Z0);
        lo_s(); expect_out("R6 drop in high: low phase", Z0, F);
        hi_s(); expect_out("R3 closed after rise+fall", Z0, F);
        lo_s(); clk_en = 1'b1;                     // raise during low
        hi_s(); expect_out("R6 raise in low: still closed", Z0, F);
        hi_s(); expect_out("R6 raise in low: open", F, Z0);
        lo_s(); clk_en = 1'b0;                     // drop during low
        hi_s(); expect_out("R6 drop in low: still open", F, Z0);
        hi_s(); expect_out("R6 drop in low: closed", Z0, F);
        hi_s(); clk_en = 1'b1;                     // raise during high
        hi_s(); expect_out("R6 raise in high: still closed", Z0, F);
        hi_s(); expect_out("R6 raise in high: open", F, Z0);
    endtask

    task automatic t_per_clk;
        lo_s(); clk_en = 1'b0;
        repeat (3) hi_s();
        #1; per_sel = 1'b1;
        repeat (2) @(posedge per_clk);
        #3; clk_en = 1'b1;
        repeat (2) @(negedge per_clk);
        for (int k = 0; k < 4; k++) begin
            @(posedge per_clk); #3; expect_out("R2 per high phase", F, Z0);
            @(negedge per_clk); #3; expect_out("R2 per low phase", Z0, F);
            #4;                      expect_out("R2 per low phase later", Z0, F);
        end
        clk_en = 1'b0;
        repeat (3) @(posedge per_clk);
        #3; expect_out("R3 closed on per clock", Z0, F);
        per_sel = 1'b0;
        repeat (2) hi_s();
        clk_en = 1'b1;
        repeat (3) hi_s();
        expect_out("R1 back on std clock", F, Z0);
    endtask

    task automatic t_float;
        hi_s(); out_en = 1'b0; #0.5;
        expect_out("R5 float in high phase", F, F);
        lo_s(); expect_out("R5 float in low phase", F, F);
        clk_en = 1'b0;
        repeat (3) hi_s();
        expect_out("R5 float while closed", F, F);
        out_en = 1'b1; #0.5;
        expect_out("R5 driven again closed", Z0, F);
        clk_en = 1'b1;
        repeat (3) hi_s();
        expect_out("R8 all pairs open together", F, Z0);
    endtask

    task automatic t_runt;
        mon_on = 1'b1;
        for (int k = 0; k < 24; k++) begin
            #(5 + (k % 7));
            clk_en = ~clk_en;
        end
        clk_en = 1'b1;
        repeat (4) hi_s();
        mon_on = 1'b0;
        chk(pulses > 0, "R9 pulses seen", pulses, 1);
        chk(min_hi >= 3.99, "R9 no short high pulse", $rtoi(min_hi * 10), 40);
    endtask

    initial begin
        t_reset();
        t_latency();
        t_per_clk();
        t_float();
        t_runt();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule